// File: doc/BRIEF.md
# Remote DMA Data-Port Engine

This block gives a host access to a network controller's local packet memory through a single narrow data port. The host loads a 16-bit start address and a 16-bit byte count into byte-wide registers, then issues a read or write command. Each access to the data port then moves either one byte or one little-endian 16-bit word, as one configuration bit selects. After each access the address steps forward and the count steps down. The address folds back into a receive ring when it reaches the ring's upper bound. When the count runs out, a completion flag is raised.

Only part of the 64 KiB local address space is backed by storage: a 32-byte identity area at the bottom and a packet buffer window. Reads that fall outside these areas return all ones, and writes that fall outside them are discarded. An interrupt status register, a mask register and a level interrupt output sit alongside the engine. Other parts of the controller set status bits through an event input. Memory is a synchronous RAM, so data-port read data arrives one cycle after the request.

Top module: `rdma_port_engine`

## Requirements
- R1: Configuration register bit 0 picks the access width: 1 means each data-port access moves 16 bits, 0 means 8 bits. A byte read returns the byte on data bits [7:0], with bits [15:8] at zero.
- R2: After each accepted access, the stored address grows by the width. If the sum equals the ring stop address (stop page shifted left by 8), the address becomes the ring start address (start page shifted left by 8).
- R3: On an accepted access, if the count is less than or equal to the width, the count becomes 0 and interrupt status bit 6 is set. Otherwise the count drops by the width.
- R4: A data-port write while the count is zero has no effect: memory, address, count and status bit 6 stay unchanged.
- R5: A command register write with bit 0 (read) or bit 1 (write) set, made while the count is zero, sets status bit 6 on the next cycle.
- R6: Local addresses 0 to 31, and BUF_BASE up to BUF_BASE+BUF_BYTES-1, are backed by memory. A byte read elsewhere returns 0x00FF and a word read elsewhere returns 0xFFFF. Writes elsewhere are dropped.
- R7: In 16-bit mode, address bit 0 is treated as zero for the access. The low data byte sits at the even address and the high data byte at the odd address.
- R8: Writing the status register clears each of bits [6:0] written as 1 and never touches bit 7. Bit 7 is 1 after reset and clears on any command register write.
- R9: The interrupt output is high exactly when status AND mask AND 0x7F is nonzero, so status bit 7 never raises it.
- R10: Data-port read data and its valid strobe appear on the cycle after the read request.
- R11: Register offsets are: 0 command, 1 and 2 address low and high, 3 and 4 count low and high, 5 configuration, 6 status, 7 mask, 8 ring start page, 9 ring stop page. Reading an offset returns the current value. Each bit set on the event input sets the matching status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_wr | input | 1 | Data-port write request |
| dp_rd | input | 1 | Data-port read request (ignored when dp_wr is high) |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data |
| dp_rvalid | output | 1 | Read data valid, one cycle after dp_rd |
| irq_evt | input | 8 | Status set pulses from other controller blocks |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with BUF_BASE at 0x4000 and BUF_BYTES at 256. With these values, the top edge of the buffer window and the unbacked addresses above it can be reached with single accesses. A ring whose stop page is 0x41 ends exactly at the window's last byte. This lets the bench exercise wrap in both widths, including a byte write into the upper half of a word that was written across the wrap. It also reaches the hole just below the window and just above the identity area.

// File: rtl/rdma_port_engine.sv
module rdma_port_engine #(
  parameter int BUF_BASE  = 16'h4000,
  parameter int BUF_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_wr,
  input  logic        dp_rd,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata,
  output logic        dp_rvalid,
  input  logic [7:0]  irq_evt,
  output logic        irq
);
  localparam int PROM_WORDS = 16;
  localparam int DEPTH      = PROM_WORDS + BUF_BYTES / 2;
  localparam int IDX_W      = $clog2(DEPTH);
  localparam logic [16:0] BUF_LO = 17'(BUF_BASE);
  localparam logic [16:0] BUF_HI = 17'(BUF_BASE + BUF_BYTES);

  localparam logic [3:0] A_CMD = 4'd0, A_ALO = 4'd1, A_AHI = 4'd2, A_CLO = 4'd3,
                         A_CHI = 4'd4, A_CFG = 4'd5, A_ISR = 4'd6, A_IMR = 4'd7,
                         A_RST = 4'd8, A_RSP = 4'd9;

  logic [15:0] addr_q, cnt_q;
  logic [7:0]  cmd_q, cfg_q, isr_q, imr_q, rstart_q, rstop_q;

  wire        wide  = cfg_q[0];
  wire [15:0] step  = wide ? 16'd2 : 16'd1;
  wire [15:0] eff   = wide ? {addr_q[15:1], 1'b0} : addr_q;
  wire        in_prom = eff < 16'd32;
  wire        in_buf  = ({1'b0, eff} >= BUF_LO) && ({1'b0, eff} < BUF_HI);
  wire        backed  = in_prom || in_buf;
  wire [14:0] boff    = eff[15:1] - BUF_LO[15:1];

  logic [IDX_W-1:0] idx;
  always_comb idx = in_prom ? IDX_W'(eff[4:1]) : IDX_W'(PROM_WORDS + int'(boff));

  wire wr_go = dp_wr && (cnt_q != 16'd0);
  wire rd_go = dp_rd && !dp_wr;
  wire acc   = wr_go || rd_go;

  wire [15:0] start_a = {rstart_q, 8'h00};
  wire [15:0] stop_a  = {rstop_q, 8'h00};
  wire [15:0] sum     = addr_q + step;
  wire [15:0] addr_nx = (sum == stop_a) ? start_a : sum;
  wire        last    = cnt_q <= step;

  wire       cmd_wr  = reg_we && (reg_addr == A_CMD);
  wire       isr_wr  = reg_we && (reg_addr == A_ISR);
  wire       zero_go = cmd_wr && (reg_wdata[1:0] != 2'b00) && (cnt_q == 16'd0);
  wire [7:0] isr_set = irq_evt | {1'b0, (acc && last) || zero_go, 6'b0};
  wire [7:0] isr_clr = {cmd_wr, isr_wr ? reg_wdata[6:0] : 7'h00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      cnt_q     <= '0;
      cmd_q     <= '0;
      cfg_q     <= '0;
      isr_q     <= 8'h80;
      imr_q     <= '0;
      rstart_q  <= '0;
      rstop_q   <= '0;
      dp_rvalid <= 1'b0;
    end else begin
      isr_q     <= (isr_q & ~isr_clr) | isr_set;
      dp_rvalid <= rd_go;
      if (acc) begin
        addr_q <= addr_nx;
        cnt_q  <= last ? 16'd0 : cnt_q - step;
      end
      if (reg_we) begin
        case (reg_addr)
          A_CMD: cmd_q         <= reg_wdata;
          A_ALO: addr_q[7:0]   <= reg_wdata;
          A_AHI: addr_q[15:8]  <= reg_wdata;
          A_CLO: cnt_q[7:0]    <= reg_wdata;
          A_CHI: cnt_q[15:8]   <= reg_wdata;
          A_CFG: cfg_q         <= reg_wdata;
          A_IMR: imr_q         <= reg_wdata;
          A_RST: rstart_q      <= reg_wdata;
          A_RSP: rstop_q       <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  logic [7:0] lane_lo [DEPTH];
  logic [7:0] lane_hi [DEPTH];
  logic [7:0] q_lo, q_hi;
  logic       q_hole, q_wide, q_odd;

  always_ff @(posedge clk) begin
    if (wr_go && backed) begin
      if (wide) begin
        lane_lo[idx] <= dp_wdata[7:0];
        lane_hi[idx] <= dp_wdata[15:8];
      end else if (eff[0]) begin
        lane_hi[idx] <= dp_wdata[7:0];
      end else begin
        lane_lo[idx] <= dp_wdata[7:0];
      end
    end
    if (rd_go) begin
      if (backed) begin
        q_lo <= lane_lo[idx];
        q_hi <= lane_hi[idx];
      end
      q_hole <= !backed;
      q_wide <= wide;
      q_odd  <= eff[0];
    end
  end

  assign dp_rdata = q_hole ? (q_wide ? 16'hFFFF : 16'h00FF)
                  : q_wide ? {q_hi, q_lo}
                  : {8'h00, q_odd ? q_hi : q_lo};

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = cmd_q;
      A_ALO:   reg_rdata = addr_q[7:0];
      A_AHI:   reg_rdata = addr_q[15:8];
      A_CLO:   reg_rdata = cnt_q[7:0];
      A_CHI:   reg_rdata = cnt_q[15:8];
      A_CFG:   reg_rdata = cfg_q;
      A_ISR:   reg_rdata = isr_q;
      A_IMR:   reg_rdata = imr_q;
      A_RST:   reg_rdata = rstart_q;
      A_RSP:   reg_rdata = rstop_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = |(isr_q[6:0] & imr_q[6:0]);

  // R4
  ign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_wr && (cnt_q == 16'd0) && !reg_we |=> $stable(addr_q) && (cnt_q == 16'd0));

  // R3
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && last && !reg_we |=> (cnt_q == 16'd0) && isr_q[6]);

  // R10
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> dp_rvalid);

  // R10
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rvalid |-> $past(rd_go));

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !reg_we && (sum == stop_a) |=> addr_q == {rstart_q, 8'h00});

  // R8
  isr7_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_wr && isr_q[7] |=> isr_q[7]);

  // R5
  zero_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (reg_wdata[1:0] != 2'b00) && (cnt_q == 16'd0) |=> isr_q[6]);
endmodule

// File: tb/rdma_port_engine_bench.sv
module rdma_port_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        dp_wr = 1'b0, dp_rd = 1'b0;
  logic [15:0] dp_wdata = '0;
  logic [15:0] dp_rdata;
  logic        dp_rvalid;
  logic [7:0]  irq_evt = '0;
  logic        irq;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rdma_port_engine #(.BUF_BASE(16'h4000), .BUF_BYTES(256)) u_rdma_port_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_wr(dp_wr), .dp_rd(dp_rd),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .dp_rvalid(dp_rvalid),
    .irq_evt(irq_evt), .irq(irq));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rreg(lo, l);
    rreg(lo + 4'd1, h);
    v = {h, l};
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] c, input logic w);
    wreg(4'd5, {7'd0, w});
    wreg(4'd1, a[7:0]); wreg(4'd2, a[15:8]);
    wreg(4'd3, c[7:0]); wreg(4'd4, c[15:8]);
  endtask

  task automatic dpw(input logic [15:0] d);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = d;
    @(negedge clk);
    dp_wr = 1'b0;
  endtask

  task automatic dpr(output logic [15:0] v);
    @(negedge clk);
    dp_rd = 1'b1;
    @(negedge clk);
    dp_rd = 1'b0;
    chk("R10 rvalid", {15'd0, dp_rvalid}, 16'd1);
    v = dp_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v; logic [15:0] w;
    rreg(4'd6, v); chk("R8 isr after reset", {8'd0, v}, 16'h0080);
    rd16(4'd3, w); chk("R11 count after reset", w, 16'h0000);
    chk("R9 irq after reset", {15'd0, irq}, 16'd0);
    chk("R10 rvalid idle", {15'd0, dp_rvalid}, 16'd0);
  endtask

  task automatic t_bit7;
    logic [7:0] v;
    wreg(4'd7, 8'hFF);
    chk("R9 bit7 no irq", {15'd0, irq}, 16'd0);
    wreg(4'd6, 8'hFF);
    rreg(4'd6, v); chk("R8 bit7 kept on isr write", {8'd0, v}, 16'h0080);
    wreg(4'd0, 8'h00);
    rreg(4'd6, v); chk("R8 bit7 cleared by cmd", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_byte;
    logic [7:0] v; logic [15:0] w;
    setup(16'h4000, 16'd3, 1'b0);
    wreg(4'd0, 8'h02);
    dpw(16'h00AA); dpw(16'h00BB); dpw(16'h00CC);
    rd16(4'd1, w); chk("R2 byte advance", w, 16'h4003);
    rd16(4'd3, w); chk("R3 byte count end", w, 16'h0000);
    rreg(4'd6, v); chk("R3 done bit", {8'd0, v}, 16'h0040);
    chk("R9 irq on done", {15'd0, irq}, 16'd1);
    wreg(4'd6, 8'h40);
    rreg(4'd6, v); chk("R8 clear done", {8'd0, v}, 16'h0000);
    chk("R9 irq cleared", {15'd0, irq}, 16'd0);
    setup(16'h4000, 16'd3, 1'b0);
    wreg(4'd0, 8'h01);
    dpr(w); chk("R1 byte read 0", w, 16'h00AA);
    dpr(w); chk("R1 byte read 1", w, 16'h00BB);
    dpr(w); chk("R1 byte read 2", w, 16'h00CC);
    wreg(4'd6, 8'h40);
  endtask

  task automatic t_word;
    logic [15:0] w;
    setup(16'h4010, 16'd4, 1'b1);
    dpw(16'h1234); dpw(16'h5678);
    rd16(4'd1, w); chk("R2 word advance", w, 16'h4014);
    setup(16'h4010, 16'd2, 1'b0);
    dpr(w); chk("R7 little-endian low", w, 16'h0034);
    dpr(w); chk("R7 little-endian high", w, 16'h0012);
    setup(16'h4013, 16'd2, 1'b1);
    dpr(w); chk("R7 odd forced even", w, 16'h5678);
    rd16(4'd1, w); chk("R2 advance from stored odd", w, 16'h4015);
    wreg(4'd6, 8'h40);
  endtask

  task automatic t_count;
    logic [7:0] v; logic [15:0] w;
    setup(16'h4030, 16'd3, 1'b1);
    dpw(16'h0001);
    rd16(4'd3, w); chk("R3 count minus width", w, 16'd1);
    rreg(4'd6, v); chk("R3 not done yet", {8'd0, v}, 16'h0000);
    dpw(16'h0002);
    rd16(4'd3, w); chk("R3 count below width", w, 16'd0);
    rreg(4'd6, v); chk("R3 done below width", {8'd0, v}, 16'h0040);
    wreg(4'd6, 8'h40);
  endtask

  task automatic t_ignore;
    logic [7:0] v; logic [15:0] w;
    setup(16'h4020, 16'd2, 1'b1);
    dpw(16'h7777);
    wreg(4'd6, 8'h40);
    setup(16'h4020, 16'd0, 1'b1);
    dpw(16'h1111);
    rd16(4'd1, w); chk("R4 address held", w, 16'h4020);
    rd16(4'd3, w); chk("R4 count held", w, 16'h0000);
    rreg(4'd6, v); chk("R4 no done", {8'd0, v}, 16'h0000);
    setup(16'h4020, 16'd2, 1'b1);
    dpr(w); chk("R4 memory held", w, 16'h7777);
    wreg(4'd6, 8'h40);
  endtask

  task automatic t_zero;
    logic [7:0] v;
    setup(16'h4000, 16'd0, 1'b0);
    wreg(4'd0, 8'h00);
    rreg(4'd6, v); chk("R5 idle cmd no done", {8'd0, v}, 16'h0000);
    wreg(4'd0, 8'h01);
    rreg(4'd6, v); chk("R5 zero read cmd", {8'd0, v}, 16'h0040);
    wreg(4'd6, 8'h40);
    wreg(4'd0, 8'h02);
    rreg(4'd6, v); chk("R5 zero write cmd", {8'd0, v}, 16'h0040);
    wreg(4'd6, 8'h40);
    setup(16'h4000, 16'd5, 1'b0);
    wreg(4'd0, 8'h02);
    rreg(4'd6, v); chk("R5 nonzero cmd no done", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_wrap;
    logic [15:0] w;
    wreg(4'd8, 8'h40); wreg(4'd9, 8'h41);
    setup(16'h40FE, 16'd4, 1'b1);
    dpw(16'hBEEF);
    rd16(4'd1, w); chk("R2 word wrap", w, 16'h4000);
    rd16(4'd3, w); chk("R3 count after wrap", w, 16'd2);
    setup(16'h40FF, 16'd2, 1'b0);
    dpw(16'h0011);
    rd16(4'd1, w); chk("R2 byte wrap", w, 16'h4000);
    setup(16'h40FE, 16'd2, 1'b1);
    dpr(w); chk("R7 merged word", w, 16'h11EF);
    wreg(4'd6, 8'h40);
  endtask

  task automatic t_hole;
    logic [15:0] w;
    setup(16'h0020, 16'd1, 1'b0);
    dpr(w); chk("R6 hole above prom", w, 16'h00FF);
    setup(16'h3FFF, 16'd1, 1'b0);
    dpr(w); chk("R6 hole below buffer", w, 16'h00FF);
    setup(16'h4100, 16'd2, 1'b1);
    dpw(16'h1111);
    setup(16'h4100, 16'd2, 1'b1);
    dpr(w); chk("R6 hole above buffer", w, 16'hFFFF);
    setup(16'h001F, 16'd1, 1'b0);
    dpw(16'h005A);
    setup(16'h001F, 16'd1, 1'b0);
    dpr(w); chk("R6 prom backed", w, 16'h005A);
    wreg(4'd6, 8'h40);
  endtask

  task automatic t_evt;
    logic [7:0] v;
    wreg(4'd7, 8'h01);
    @(negedge clk); irq_evt = 8'h01;
    @(negedge clk); irq_evt = 8'h00;
    rreg(4'd6, v); chk("R11 event sets status", {8'd0, v}, 16'h0001);
    chk("R9 irq on event", {15'd0, irq}, 16'd1);
    wreg(4'd7, 8'h02);
    chk("R9 masked event", {15'd0, irq}, 16'd0);
    wreg(4'd6, 8'h01);
    rreg(4'd6, v); chk("R8 event cleared", {8'd0, v}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_bit7; t_byte; t_word; t_count;
    t_ignore; t_zero; t_wrap; t_hole; t_evt;
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog got hang exp finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule